// File: doc/BRIEF.md
# Bridge Inbound Inverse Address Decoder

This block sits on the secondary-bus side of a bridge and decides, in a single combinational step, whether a transaction observed there should be claimed and sent upstream. It claims by subtraction: the bridge's downstream windows (memory, prefetchable memory and I/O, plus the optional legacy VGA and ISA ranges) describe what lives below the bridge. Any address that misses every enabled window must belong upstream, so the block claims it, as long as it lies inside the address space the upstream side can carry and the bridge is allowed to master.

The inputs are a command class, a 64-bit address with a dual-address-cycle flag, and the configuration values. The outputs are a claim flag and a reason code that tells why the transaction was or was not claimed. Only the decode is built. Register storage, bus timing and the data path belong to other blocks.

Top module: `inbound_inv_decode`

## Requirements
- R1: Only command class 1 (memory) or 2 (I/O) can be claimed. Classes 0 (configuration) and 3 (special) give reason 1 (not a target). Reason codes are: 0 claim, 1 not a target, 2 out of space, 3 inside a forwarding window, 4 VGA excluded, 5 master disabled. `claim` is high exactly when the reason is 0.
- R2: For memory, a single-address cycle (`dual_addr`=0) uses only address bits [31:0], and bits [63:32] are taken as zero. A dual-address cycle uses all 64 bits.
- R3: A memory address with any of the top 24 bits [63:40] set gives reason 2.
- R4: A memory address inside the inclusive range `mem_base`..`mem_limit` (40-bit byte addresses) gives reason 3.
- R5: A memory address inside the inclusive 40-bit prefetchable range `pref_base`..`pref_limit`, which covers addresses above 4 GB, gives reason 3.
- R6: A memory address whose bits [39:32] exceed 0xFC gives reason 2.
- R7: With `vga_en` set, memory addresses 0x00_000A_0000 through 0x00_000B_FFFF give reason 4. With `vga_en` clear, they are not excluded.
- R8: I/O uses address bits [31:0], and the space is 25 bits. Any of bits [31:25] set gives reason 2.
- R9: An I/O address inside the inclusive 25-bit range `io_base`..`io_limit` gives reason 3. The exception is when `isa_en` is set, the address is below 0x10000, and bits [9:8] are not 00. Such an address is in an ISA hole and is not excluded by the window.
- R10: With `vga_en` set, an I/O address below 0x10000 whose bits [9:0] lie in 0x3B0..0x3BB or 0x3C0..0x3DF gives reason 4, provided the window has not already excluded it.
- R11: A window whose base is greater than its limit is empty and excludes nothing.
- R12: An in-space transaction that no window excludes gives reason 0 when `master_en` is set and reason 5 when it is clear. Reason priority is 1, then 2, then 3, then 4, then 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmd_kind | input | 2 | Command class: 0 config, 1 memory, 2 I/O, 3 special |
| addr | input | 64 | Transaction address |
| dual_addr | input | 1 | Dual-address cycle: upper 32 address bits are valid |
| mem_base | input | 40 | Memory window lower bound |
| mem_limit | input | 40 | Memory window upper bound |
| pref_base | input | 40 | Prefetchable window lower bound |
| pref_limit | input | 40 | Prefetchable window upper bound |
| io_base | input | 25 | I/O window lower bound |
| io_limit | input | 25 | I/O window upper bound |
| vga_en | input | 1 | Enable the legacy VGA exclusions |
| isa_en | input | 1 | Enable ISA holes in the I/O window |
| master_en | input | 1 | Bridge may master upstream |
| claim | output | 1 | Transaction is claimed for upstream forwarding |
| reason | output | 3 | Decode outcome code |

## Verification
Addresses are placed exactly on each window's base and limit and one byte outside them. This distinguishes inclusive bounds from off-by-one bounds, and the same probes with a reversed base and limit show that an empty window excludes nothing. Single- and dual-address cycles are sent with junk in the upper bits, which separates ignored bits from checked bits, and the 0xFC/0xFD and bit-40 boundaries separate the two out-of-space rules. For I/O, the same low offsets are tried inside and outside 64 KB with the ISA and VGA enables toggled. This shows the holes and VGA aliases apply only in the low region, and the master-enable sweep confirms that exclusions take priority over the master-disabled outcome.

// File: rtl/inbound_inv_decode.sv
module inbound_inv_decode #(
  parameter int ADDR_W      = 64,
  parameter int MEM_AW      = 40,
  parameter int IO_AW       = 25,
  parameter int MEM_TOP_MAX = 252
) (
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dual_addr,
  input  logic [MEM_AW-1:0] mem_base,
  input  logic [MEM_AW-1:0] mem_limit,
  input  logic [MEM_AW-1:0] pref_base,
  input  logic [MEM_AW-1:0] pref_limit,
  input  logic [IO_AW-1:0]  io_base,
  input  logic [IO_AW-1:0]  io_limit,
  input  logic              vga_en,
  input  logic              isa_en,
  input  logic              master_en,
  output logic              claim,
  output logic [2:0]        reason
);
  localparam int HIW = MEM_AW - 32;
  localparam logic [HIW-1:0]    TOP_MAX = HIW'(MEM_TOP_MAX);
  localparam logic [MEM_AW-1:0] VGA_LO  = MEM_AW'(40'h00_000A_0000);
  localparam logic [MEM_AW-1:0] VGA_HI  = MEM_AW'(40'h00_000B_FFFF);

  localparam logic [2:0] RS_CLAIM = 3'd0, RS_NOTGT = 3'd1, RS_SPACE = 3'd2,
                         RS_WIN = 3'd3, RS_VGA = 3'd4, RS_MOFF = 3'd5;

  wire is_mem = (cmd_kind == 2'd1);
  wire is_io  = (cmd_kind == 2'd2);

  wire [ADDR_W-1:0] eff = dual_addr ? addr : {{(ADDR_W-32){1'b0}}, addr[31:0]};
  wire [MEM_AW-1:0] ma  = eff[MEM_AW-1:0];

  wire mem_space = (eff[ADDR_W-1:MEM_AW] == '0) && (eff[MEM_AW-1:32] <= TOP_MAX);
  wire mem_win   = (ma >= mem_base  && ma <= mem_limit) ||
                   (ma >= pref_base && ma <= pref_limit);
  wire mem_vga   = vga_en && ma >= VGA_LO && ma <= VGA_HI;

  wire [IO_AW-1:0] ia = addr[IO_AW-1:0];
  wire [9:0]       lo10 = addr[9:0];
  wire io_space  = (addr[31:IO_AW] == '0);
  wire io_low    = (addr[31:16] == '0);
  wire isa_hole  = isa_en && io_low && (addr[9:8] != 2'b00);
  wire io_win    = !isa_hole && ia >= io_base && ia <= io_limit;
  wire io_vga    = vga_en && io_low &&
                   ((lo10 >= 10'h3B0 && lo10 <= 10'h3BB) ||
                    (lo10 >= 10'h3C0 && lo10 <= 10'h3DF));

  wire in_space = is_mem ? mem_space : io_space;
  wire in_win   = is_mem ? mem_win   : io_win;
  wire in_vga   = is_mem ? mem_vga   : io_vga;

  always_comb begin
    if (!(is_mem || is_io)) reason = RS_NOTGT;
    else if (!in_space)     reason = RS_SPACE;
    else if (in_win)        reason = RS_WIN;
    else if (in_vga)        reason = RS_VGA;
    else if (!master_en)    reason = RS_MOFF;
    else                    reason = RS_CLAIM;
  end

  assign claim = (reason == RS_CLAIM);

  always_comb begin
    if (claim) begin
      a_r1_claim_cmd: assert (cmd_kind == 2'd1 || cmd_kind == 2'd2);
      a_r12_claim_master: assert (master_en);
    end
    if (claim && is_mem && dual_addr)
      a_r3_claim_top_zero: assert (addr[ADDR_W-1:MEM_AW] == '0);
    if (claim && is_mem && vga_en)
      a_r7_claim_not_vga_mem: assert (eff[MEM_AW-1:17] != 'd5);
    if (claim && is_io)
      a_r8_claim_io_space: assert (addr[31:IO_AW] == '0);
    if (claim && is_io && vga_en && addr[31:16] == '0)
      a_r10_claim_not_vga_io: assert (!(addr[9:4] == 6'h3C || addr[9:4] == 6'h3D ||
                                        (addr[9:4] == 6'h3B && addr[3:2] != 2'b11)));
  end
endmodule

// File: tb/inbound_inv_decode_tb.sv
module inbound_inv_decode_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic [1:0]  cmd_kind;
  logic [63:0] addr;
  logic        dual_addr;
  logic [39:0] mem_base, mem_limit, pref_base, pref_limit;
  logic [24:0] io_base, io_limit;
  logic        vga_en, isa_en, master_en;
  logic        claim;
  logic [2:0]  reason;

  inbound_inv_decode u_dut (
    .cmd_kind(cmd_kind), .addr(addr), .dual_addr(dual_addr),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .pref_base(pref_base), .pref_limit(pref_limit),
    .io_base(io_base), .io_limit(io_limit),
    .vga_en(vga_en), .isa_en(isa_en), .master_en(master_en),
    .claim(claim), .reason(reason)
  );

  typedef struct { logic [2:0] r; string tag; logic [63:0] a; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  localparam logic [1:0] K_CFG = 2'd0, K_MEM = 2'd1, K_IO = 2'd2, K_SPC = 2'd3;

  task automatic drive(input logic [1:0] k, input logic [63:0] a, input logic d,
                       input logic [2:0] r, input string tag);
    exp_t e;
    @(posedge clk); #1;
    cmd_kind = k; addr = a; dual_addr = d;
    e.r = r; e.tag = tag; e.a = a;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (reason !== e.r || claim !== (e.r == 3'd0)) begin
        n_bad++;
        $display("FAIL %s addr=%h: reason=%0d claim=%0b expected reason=%0d claim=%0b",
                 e.tag, e.a, reason, claim, e.r, (e.r == 3'd0));
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cmd_kind = K_CFG; addr = '0; dual_addr = 0;
    mem_base = 40'h00_8000_0000; mem_limit = 40'h00_8FFF_FFFF;
    pref_base = 40'h12_0000_0000; pref_limit = 40'h12_FFFF_FFFF;
    io_base = 25'h1000; io_limit = 25'h1FFF;
    vga_en = 0; isa_en = 0; master_en = 1;
    repeat (3) @(posedge clk);
    rst_n = 1;

    drive(K_CFG, 64'h0, 0, 3'd1, "R1 config idle");
    drive(K_SPC, 64'h1000_0000, 0, 3'd1, "R1 special");
    drive(K_MEM, 64'h1000_0000, 0, 3'd0, "R12 mem claim");
    drive(K_MEM, 64'hFFFF_FFFF_1000_0000, 0, 3'd0, "R2 single-addr ignores upper");
    drive(K_MEM, 64'hFFFF_FFFF_1000_0000, 1, 3'd2, "R3 dual-addr top bits");
    drive(K_MEM, 64'h0100_0000_0000_0000, 1, 3'd2, "R3 bit56");
    drive(K_MEM, 64'h0000_0100_0000_0000, 1, 3'd2, "R3 bit40");
    drive(K_MEM, 64'h8000_0000, 0, 3'd3, "R4 mem base");
    drive(K_MEM, 64'h8FFF_FFFF, 0, 3'd3, "R4 mem limit");
    drive(K_MEM, 64'h7FFF_FFFF, 0, 3'd0, "R4 below base");
    drive(K_MEM, 64'h9000_0000, 0, 3'd0, "R4 above limit");
    drive(K_MEM, 64'h12_0000_0000, 1, 3'd3, "R5 pref base");
    drive(K_MEM, 64'h12_4000_0000, 1, 3'd3, "R5 pref mid");
    drive(K_MEM, 64'h12_FFFF_FFFF, 1, 3'd3, "R5 pref limit");
    drive(K_MEM, 64'h11_FFFF_FFFF, 1, 3'd0, "R5 below pref");
    drive(K_MEM, 64'h13_0000_0000, 1, 3'd0, "R5 above pref");
    drive(K_MEM, 64'h12_4000_0000, 0, 3'd0, "R2 pref addr as single-addr");
    drive(K_MEM, 64'hFC_FFFF_FFFF, 1, 3'd0, "R6 top FC");
    drive(K_MEM, 64'hFD_0000_0000, 1, 3'd2, "R6 top FD");
    drive(K_MEM, 64'hFF_0000_0000, 1, 3'd2, "R6 top FF");
    drive(K_MEM, 64'hA_0000, 0, 3'd0, "R7 vga off");
    drive(K_IO, 64'h3B0, 0, 3'd0, "R10 vga off io");
    drive(K_IO, 64'h1000, 0, 3'd3, "R9 io base");
    drive(K_IO, 64'h1FFF, 0, 3'd3, "R9 io limit");
    drive(K_IO, 64'h0FFF, 0, 3'd0, "R9 io below");
    drive(K_IO, 64'h2000, 0, 3'd0, "R9 io above");
    drive(K_IO, 64'h1100, 0, 3'd3, "R9 isa off no hole");
    drive(K_IO, 64'h01FF_FFFF, 0, 3'd0, "R8 io top of space");
    drive(K_IO, 64'h0200_0000, 0, 3'd2, "R8 io bit25");
    drive(K_IO, 64'h8000_0000, 0, 3'd2, "R8 io bit31");
    drive(K_IO, 64'hFFFF_FFFF_0000_2000, 1, 3'd0, "R8 io ignores upper 32");

    @(posedge clk); #1; vga_en = 1;
    drive(K_MEM, 64'hA_0000, 0, 3'd4, "R7 vga lo");
    drive(K_MEM, 64'hB_FFFF, 0, 3'd4, "R7 vga hi");
    drive(K_MEM, 64'h9_FFFF, 0, 3'd0, "R7 below vga");
    drive(K_MEM, 64'hC_0000, 0, 3'd0, "R7 above vga");
    drive(K_MEM, 64'h1_000A_0000, 1, 3'd0, "R7 vga alias above 4G");
    drive(K_IO, 64'h3B0, 0, 3'd4, "R10 3B0");
    drive(K_IO, 64'h3BB, 0, 3'd4, "R10 3BB");
    drive(K_IO, 64'h3BC, 0, 3'd0, "R10 3BC");
    drive(K_IO, 64'h3AF, 0, 3'd0, "R10 3AF");
    drive(K_IO, 64'h3C0, 0, 3'd4, "R10 3C0");
    drive(K_IO, 64'h3DF, 0, 3'd4, "R10 3DF");
    drive(K_IO, 64'h3E0, 0, 3'd0, "R10 3E0");
    drive(K_IO, 64'h7B0, 0, 3'd4, "R10 alias 7B0");
    drive(K_IO, 64'h1_03B0, 0, 3'd0, "R10 above 64K");

    @(posedge clk); #1; io_base = 25'h0; io_limit = 25'h1_FFFF; vga_en = 0; isa_en = 1;
    drive(K_IO, 64'h1000, 0, 3'd3, "R9 isa kept low quarter");
    drive(K_IO, 64'h10FF, 0, 3'd3, "R9 isa kept 10FF");
    drive(K_IO, 64'h1100, 0, 3'd0, "R9 isa hole 1100");
    drive(K_IO, 64'h13FF, 0, 3'd0, "R9 isa hole 13FF");
    drive(K_IO, 64'h1400, 0, 3'd3, "R9 isa kept 1400");
    drive(K_IO, 64'h1_1100, 0, 3'd3, "R9 no hole above 64K");
    @(posedge clk); #1; vga_en = 1;
    drive(K_IO, 64'h3C0, 0, 3'd4, "R10 vga in isa hole");
    drive(K_IO, 64'h0C0, 0, 3'd3, "R10 window before vga");

    @(posedge clk); #1;
    isa_en = 0; vga_en = 0;
    io_base = 25'h2000; io_limit = 25'h1000;
    mem_base = 40'h00_9000_0000; mem_limit = 40'h00_8000_0000;
    pref_base = 40'h13_0000_0000; pref_limit = 40'h12_0000_0000;
    drive(K_IO, 64'h1800, 0, 3'd0, "R11 empty io window");
    drive(K_IO, 64'h2000, 0, 3'd0, "R11 empty io at base");
    drive(K_MEM, 64'h8800_0000, 0, 3'd0, "R11 empty mem window");
    drive(K_MEM, 64'h12_8000_0000, 1, 3'd0, "R11 empty pref window");

    @(posedge clk); #1;
    mem_base = 40'h00_8000_0000; mem_limit = 40'h00_8FFF_FFFF; master_en = 0; vga_en = 1;
    drive(K_MEM, 64'h1000_0000, 0, 3'd5, "R12 mem master off");
    drive(K_MEM, 64'h8000_0000, 0, 3'd3, "R12 window beats master off");
    drive(K_MEM, 64'hA_0000, 0, 3'd4, "R12 vga beats master off");
    drive(K_MEM, 64'hFD_0000_0000, 1, 3'd2, "R12 space beats master off");
    drive(K_IO, 64'h3000, 0, 3'd5, "R12 io master off");
    drive(K_CFG, 64'h3000, 0, 3'd1, "R12 not-target beats all");

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule